// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for each of the two ALU operands of the instruction now in the execute stage, where that operand's value must come from. The value can come from the register file, from the result held in the execute/memory pipeline register, or from the result held in the memory/write-back pipeline register. It compares each execute-stage source register number with the destination numbers and write enables of the two older instructions still in flight. It then drives a two-bit select per operand and the three-way multiplexer that select controls.

All logic is combinational. The selects and the forwarded operands settle in the same cycle as their inputs. When both older stages write the register being read, the younger one, in the execute/memory stage, wins, because it carries the newer value. A stage whose write enable is low never forwards. A destination of register 0 never forwards either, since that register always reads as zero. No path from write-back back into decode is needed, because a register-file write lands before a read in the same cycle.

The structure repeats per operand: a match comparator for each older stage, a priority selector, and an operand multiplexer. Register-number width, data width and operand count are parameters.

Top module: `fwd_unit_top`

## Requirements
- R1: `sel_a` is 2'b10 (take the execute/memory result) whenever `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `ex_src_a`.
- R2: `sel_b` is 2'b10 whenever `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `ex_src_b`.
- R3: An operand's select is 2'b01 (take the memory/write-back result) when `wbk_wen` is 1, `wbk_dst` is nonzero and equals that operand's source, and the R1/R2 condition for that operand does not hold.
- R4: When both older stages match the same source register, the select is 2'b10. The newest producer wins, so a chain of instructions writing one register forwards the latest result.
- R5: A destination number of 0 never causes forwarding from either stage.
- R6: A stage whose write enable is 0 never causes forwarding, whatever its destination number.
- R7: With no qualifying match, the select is 2'b00 and the operand equals the register-file value for that operand.
- R8: Each operand output equals `exm_data` when its select is 2'b10, `wbk_data` when its select is 2'b01, and its register-file input when its select is 2'b00.
- R9: The select value 2'b11 never appears on either output.
- R10: Both operands are resolved independently. Operand A and operand B may pick different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register number of the execute-stage instruction |
| exm_dst | input | 5 | Destination register held in the execute/memory pipeline register |
| exm_wen | input | 1 | Register-write enable held in the execute/memory pipeline register |
| exm_data | input | 32 | Result value held in the execute/memory pipeline register |
| wbk_dst | input | 5 | Destination register held in the memory/write-back pipeline register |
| wbk_wen | input | 1 | Register-write enable held in the memory/write-back pipeline register |
| wbk_data | input | 32 | Result value held in the memory/write-back pipeline register |
| rf_data_a | input | 32 | Register-file read value for operand A |
| rf_data_b | input | 32 | Register-file read value for operand B |
| sel_a | output | 2 | Source select for operand A (00 file, 10 execute/memory, 01 memory/write-back) |
| sel_b | output | 2 | Source select for operand B, same encoding |
| opnd_a | output | 32 | Forwarded operand A |
| opnd_b | output | 32 | Forwarded operand B |

## Verification
Every result of this block is due in the same cycle as the inputs that cause it, so zero cycles of latency separate a stimulus from its check. The bench changes inputs just after a rising clock edge and samples selects and operands at the following falling edge. The combinational paths have settled by then, and no clock edge lies between the stimulus and the sample. A replayed instruction sequence shifts bench-side pipeline registers once per cycle, so each check compares against the stage contents that were applied in that same cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 2;

    // Operand source select; the encoding is visible on the top-level ports.
    typedef enum logic [SEL_W-1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBK     = 2'b01,
        SRC_EXM     = 2'b10
    } src_sel_e;

endpackage

// File: rtl/fwd_match.sv
// Compares one older stage's destination against one source register number.
module fwd_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_idx,
    input  logic [REG_W-1:0] dst_idx,
    input  logic             wr_en,
    output logic             hit
);
    logic dst_live;

    always_comb begin
        dst_live = (dst_idx != '0);
        hit      = wr_en && dst_live && (dst_idx == src_idx);
    end

    always_comb begin
        if (!wr_en) begin
            assert_no_hit_without_wen_R6: assert (!hit);
        end
    end
endmodule

// File: rtl/fwd_select.sv
// Priority between the two older stages: the younger stage wins.
module fwd_select
    import fwd_pkg::*;
(
    input  logic     exm_hit,
    input  logic     wbk_hit,
    output src_sel_e sel
);
    always_comb begin
        unique case ({exm_hit, wbk_hit})
            2'b10, 2'b11: sel = SRC_EXM;
            2'b01:        sel = SRC_WBK;
            default:      sel = SRC_REGFILE;
        endcase
    end

    always_comb begin
        if (exm_hit && wbk_hit) begin
            assert_young_stage_wins_R4: assert (sel == SRC_EXM);
        end
    end
endmodule

// File: rtl/fwd_operand_mux.sv
// Three-way operand multiplexer driven by the forwarding select.
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] wbk_val,
    output logic [DATA_W-1:0] opnd
);
    always_comb begin
        unique case (sel)
            SRC_EXM:     opnd = exm_val;
            SRC_WBK:     opnd = wbk_val;
            SRC_REGFILE: opnd = rf_val;
            default:     opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
    import fwd_pkg::*;
#(
    parameter int P_REG_W  = fwd_pkg::REG_W,
    parameter int P_DATA_W = fwd_pkg::DATA_W
) (
    input  logic [P_REG_W-1:0]  ex_src_a,
    input  logic [P_REG_W-1:0]  ex_src_b,
    input  logic [P_REG_W-1:0]  exm_dst,
    input  logic                exm_wen,
    input  logic [P_DATA_W-1:0] exm_data,
    input  logic [P_REG_W-1:0]  wbk_dst,
    input  logic                wbk_wen,
    input  logic [P_DATA_W-1:0] wbk_data,
    input  logic [P_DATA_W-1:0] rf_data_a,
    input  logic [P_DATA_W-1:0] rf_data_b,
    output logic [1:0]          sel_a,
    output logic [1:0]          sel_b,
    output logic [P_DATA_W-1:0] opnd_a,
    output logic [P_DATA_W-1:0] opnd_b
);
    localparam int NUM_OPND = 2;

    logic [P_REG_W-1:0]  src_arr [NUM_OPND];
    logic [P_DATA_W-1:0] rf_arr  [NUM_OPND];
    logic [P_DATA_W-1:0] opnd_arr[NUM_OPND];
    src_sel_e            sel_arr [NUM_OPND];

    always_comb begin
        src_arr[0] = ex_src_a;
        src_arr[1] = ex_src_b;
        rf_arr[0]  = rf_data_a;
        rf_arr[1]  = rf_data_b;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        logic exm_hit;
        logic wbk_hit;

        fwd_match #(.REG_W(P_REG_W)) i_exm_match (
            .src_idx (src_arr[g]),
            .dst_idx (exm_dst),
            .wr_en   (exm_wen),
            .hit     (exm_hit)
        );

        fwd_match #(.REG_W(P_REG_W)) i_wbk_match (
            .src_idx (src_arr[g]),
            .dst_idx (wbk_dst),
            .wr_en   (wbk_wen),
            .hit     (wbk_hit)
        );

        fwd_select i_select (
            .exm_hit (exm_hit),
            .wbk_hit (wbk_hit),
            .sel     (sel_arr[g])
        );

        fwd_operand_mux #(.DATA_W(P_DATA_W)) i_mux (
            .sel     (sel_arr[g]),
            .rf_val  (rf_arr[g]),
            .exm_val (exm_data),
            .wbk_val (wbk_data),
            .opnd    (opnd_arr[g])
        );

        // Port-level checks per operand.
        always_comb begin
            assert_sel_legal_R9: assert (sel_arr[g] != src_sel_e'(2'b11));
            if (exm_dst == '0 && wbk_dst == '0) begin
                assert_zero_dst_R5: assert (sel_arr[g] == SRC_REGFILE);
            end
            if (sel_arr[g] == SRC_EXM) begin
                assert_exm_path_R8: assert (opnd_arr[g] == exm_data);
            end
            if (sel_arr[g] == SRC_WBK) begin
                assert_wbk_path_R8: assert (opnd_arr[g] == wbk_data);
            end
            if (sel_arr[g] == SRC_REGFILE) begin
                assert_rf_path_R7: assert (opnd_arr[g] == rf_arr[g]);
            end
        end
    end

    always_comb begin
        sel_a  = sel_arr[0];
        sel_b  = sel_arr[1];
        opnd_a = opnd_arr[0];
        opnd_b = opnd_arr[1];
    end

    always_comb begin
        if (exm_wen && exm_dst != '0 && exm_dst == ex_src_a) begin
            assert_exm_fwd_a_R1: assert (sel_a == 2'b10);
        end
        if (exm_wen && exm_dst != '0 && exm_dst == ex_src_b) begin
            assert_exm_fwd_b_R2: assert (sel_b == 2'b10);
        end
    end
endmodule

// File: tb/test_fwd_unit_top.sv
module test_fwd_unit_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0]  ex_src_a, ex_src_b, exm_dst, wbk_dst;
    logic        exm_wen, wbk_wen;
    logic [31:0] exm_data, wbk_data, rf_data_a, rf_data_b;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    fwd_unit_top i_fwd_unit_top (
        .ex_src_a (ex_src_a), .ex_src_b (ex_src_b),
        .exm_dst  (exm_dst),  .exm_wen  (exm_wen),  .exm_data (exm_data),
        .wbk_dst  (wbk_dst),  .wbk_wen  (wbk_wen),  .wbk_data (wbk_data),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Reference priority model built from the requirements.
    function automatic logic [1:0] ref_sel(input logic [4:0] src);
        if (exm_wen && exm_dst != 5'd0 && exm_dst == src) return 2'b10;
        if (wbk_wen && wbk_dst != 5'd0 && wbk_dst == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] ref_opnd(input logic [1:0] s, input logic [31:0] rf);
        if (s == 2'b10) return exm_data;
        if (s == 2'b01) return wbk_data;
        return rf;
    endfunction

    task automatic check_val(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one set of stage contents after a rising edge, sample at the falling edge.
    task automatic apply(input string req,
                         input logic [4:0] sa, input logic [4:0] sb,
                         input logic [4:0] ed, input logic ew, input logic [31:0] edat,
                         input logic [4:0] wd, input logic ww, input logic [31:0] wdat);
        logic [1:0] ea, eb;
        @(posedge clk);
        ex_src_a = sa; ex_src_b = sb;
        exm_dst = ed; exm_wen = ew; exm_data = edat;
        wbk_dst = wd; wbk_wen = ww; wbk_data = wdat;
        rf_data_a = 32'hA000_0000 | 32'(sa);
        rf_data_b = 32'hB000_0000 | 32'(sb);
        @(negedge clk);
        ea = ref_sel(sa);
        eb = ref_sel(sb);
        check_val(req, "sel_a",  32'(sel_a), 32'(ea));
        check_val(req, "sel_b",  32'(sel_b), 32'(eb));
        check_val(req, "opnd_a", opnd_a, ref_opnd(ea, rf_data_a));
        check_val(req, "opnd_b", opnd_b, ref_opnd(eb, rf_data_b));
    endtask

    task automatic t_idle_R7();
        apply("R7", 5'd0, 5'd0, 5'd0, 1'b0, 32'h0, 5'd0, 1'b0, 32'h0);
        check_val("R7", "idle sel_a", 32'(sel_a), 32'd0);
        apply("R7", 5'd3, 5'd4, 5'd5, 1'b1, 32'h11, 5'd6, 1'b1, 32'h22);
        check_val("R7", "no-match opnd_a", opnd_a, 32'hA000_0003);
    endtask

    task automatic t_exm_R1_R2();
        apply("R1", 5'd7, 5'd9, 5'd7, 1'b1, 32'h1234, 5'd0, 1'b0, 32'h0);
        check_val("R1", "sel_a exm", 32'(sel_a), 32'h2);
        apply("R2", 5'd8, 5'd12, 5'd12, 1'b1, 32'h5678, 5'd0, 1'b0, 32'h0);
        check_val("R2", "sel_b exm", 32'(sel_b), 32'h2);
        check_val("R8", "opnd_b exm", opnd_b, 32'h5678);
    endtask

    task automatic t_wbk_R3();
        apply("R3", 5'd10, 5'd11, 5'd2, 1'b1, 32'h1, 5'd10, 1'b1, 32'hCAFE);
        check_val("R3", "sel_a wbk", 32'(sel_a), 32'h1);
        check_val("R8", "opnd_a wbk", opnd_a, 32'hCAFE);
        apply("R3", 5'd10, 5'd11, 5'd11, 1'b0, 32'h1, 5'd11, 1'b1, 32'hBEEF);
        check_val("R3", "sel_b wbk under dead exm", 32'(sel_b), 32'h1);
    endtask

    task automatic t_both_R4();
        apply("R4", 5'd1, 5'd1, 5'd1, 1'b1, 32'h0000_0030, 5'd1, 1'b1, 32'h0000_0020);
        check_val("R4", "sel_a both", 32'(sel_a), 32'h2);
        check_val("R4", "opnd_b newest", opnd_b, 32'h30);
    endtask

    task automatic t_zero_R5();
        apply("R5", 5'd0, 5'd0, 5'd0, 1'b1, 32'hDEAD, 5'd0, 1'b1, 32'hFACE);
        check_val("R5", "opnd_a r0", opnd_a, 32'hA000_0000);
        check_val("R5", "sel_b r0", 32'(sel_b), 32'h0);
    endtask

    task automatic t_wen_R6();
        apply("R6", 5'd4, 5'd4, 5'd4, 1'b0, 32'h77, 5'd4, 1'b0, 32'h88);
        check_val("R6", "opnd_a no wen", opnd_a, 32'hA000_0004);
        check_val("R6", "sel_b no wen", 32'(sel_b), 32'h0);
    endtask

    task automatic t_split_R10();
        apply("R10", 5'd5, 5'd6, 5'd5, 1'b1, 32'h55, 5'd6, 1'b1, 32'h66);
        check_val("R10", "sel_a split", 32'(sel_a), 32'h2);
        check_val("R10", "sel_b split", 32'(sel_b), 32'h1);
    endtask

    // Replay a dependent sequence through bench-side pipeline registers.
    task automatic t_chain_R4();
        logic [4:0]  p_dst [3];
        logic        p_wen [3];
        logic [4:0]  p_sa  [3];
        logic [4:0]  p_sb  [3];
        logic [31:0] p_res [3];
        logic [4:0]  seq_dst[8] = '{5'd1, 5'd1, 5'd1, 5'd2, 5'd0, 5'd2, 5'd3, 5'd1};
        logic [4:0]  seq_sa [8] = '{5'd1, 5'd1, 5'd1, 5'd1, 5'd2, 5'd2, 5'd2, 5'd3};
        logic [4:0]  seq_sb [8] = '{5'd2, 5'd3, 5'd4, 5'd1, 5'd1, 5'd0, 5'd1, 5'd2};
        logic        seq_wen[8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
        for (int k = 0; k < 3; k++) begin
            p_dst[k] = '0; p_wen[k] = 1'b0; p_sa[k] = '0; p_sb[k] = '0; p_res[k] = '0;
        end
        for (int i = 0; i < 10; i++) begin
            p_dst[2] = p_dst[1]; p_wen[2] = p_wen[1]; p_res[2] = p_res[1];
            p_dst[1] = p_dst[0]; p_wen[1] = p_wen[0]; p_res[1] = p_res[0];
            p_dst[0] = (i < 8) ? seq_dst[i] : 5'd0;
            p_wen[0] = (i < 8) ? seq_wen[i] : 1'b0;
            p_sa[0]  = (i < 8) ? seq_sa[i]  : 5'd0;
            p_sb[0]  = (i < 8) ? seq_sb[i]  : 5'd0;
            p_res[0] = 32'h100 + 32'(i);
            apply("R4", p_sa[0], p_sb[0], p_dst[1], p_wen[1], p_res[1],
                  p_dst[2], p_wen[2], p_res[2]);
        end
    endtask

    task automatic t_sweep_R1();
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            apply("R1", {2'b00, lf[2:0]}, {2'b00, lf[5:3]}, {2'b00, lf[8:6]}, lf[9],
                  32'h0E00_0000 | 32'(i), {2'b00, lf[12:10]}, lf[13], 32'h0B00_0000 | 32'(i));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ex_src_a = '0; ex_src_b = '0; exm_dst = '0; wbk_dst = '0;
        exm_wen = 1'b0; wbk_wen = 1'b0;
        exm_data = '0; wbk_data = '0; rf_data_a = '0; rf_data_b = '0;
        t_idle_R7();
        t_exm_R1_R2();
        t_wbk_R3();
        t_both_R4();
        t_zero_R5();
        t_wen_R6();
        t_split_R10();
        t_chain_R4();
        t_sweep_R1();
        finish_run();
    end
endmodule